// File: doc/BRIEF.md
# Split 64-bit Register Access Bridge

This block puts a small bank of 64-bit registers on a 32-bit register bus. Each 64-bit register takes up two neighbouring 32-bit words: word index 2n and 2n+1, which are byte offsets +0x0 and +0x4 from its base. Writes arrive in two halves. A write to the lower-address word goes into a staging register and the register does not change yet. The write to the higher-address word then commits the staged word and the new word together in one clock edge. Reads also come in two halves. Reading the lower-address word captures the whole register at that moment, and the following read of the higher-address word returns the captured half. A free-running counter that carries between the two reads therefore never gives a torn value.

Register 0 is a configuration register whose bit 31 requests a soft reset. Register 1 is a plain read/write register. Registers 2 and up are 64-bit event counters, and each one steps by one on every cycle that its increment input is high. A configuration input picks which half of the value sits at the lower address.

Two small state machines do the sequencing. The write stager has states W_EMPTY and W_HELD:
- A lower-word write moves it to W_HELD.
- A higher-word write commits and returns it to W_EMPTY.

The read latch has states R_EMPTY and R_HELD:
- A lower-word read snapshots the register and moves it to R_HELD.
- Any higher-word read returns it to R_EMPTY.
- A soft reset also returns it to R_EMPTY.

Top module: `split64_reg_bridge`

## Requirements
- R1: After reset every register reads 0, cfg_value is 0, soft_rst is 0 and bus_rvalid is 0.
- R2: A write to the lower word of a register (word bit 0 = 0) only stages the data. The register keeps its old value until the matching commit.
- R3: A write to the higher word (word bit 0 = 1) commits the staged word and the written word as one 64-bit value in a single cycle. For register 0 the value also appears on cfg_value, with bit 31 read back as 0.
- R4: With word_swap = 0 the most-significant half sits at the lower word and the least-significant half at the higher word. With word_swap = 1 the two halves are exchanged, for both writes and reads.
- R5: Each commit clears the staging register. A higher-word write with nothing staged puts zero in the staged half: the upper half when word_swap = 0, the lower half when word_swap = 1.
- R6: A commit to register 0 whose 64-bit value has bit 31 set does the following:
  - It raises soft_rst for exactly one cycle.
  - It clears every register.
  - It discards any held read snapshot.
- R7: A lower-word read captures the whole 64-bit register. The next higher-word read of the same register returns the captured half, even if the register has changed since.
- R8: A new lower-word read replaces any earlier snapshot. A higher-word read returns the live value when no snapshot is held or the snapshot belongs to another register. Every higher-word read ends the held snapshot.
- R9: Counter k (register k+2) adds 1 on each cycle that cnt_inc[k] is 1, carrying across bit 32. A commit to the counter takes priority over the increment in that cycle.
- R10: A read strobe gives bus_rvalid = 1 with bus_rdata in the next cycle. bus_rvalid is 0 after a cycle without a read.
- R11: Writes to a register index of NUM_REGS or more are ignored and leave the staged word untouched. Reads of such indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_word_addr | input | ADDR_W | 32-bit word address; bit 0 selects the half, upper bits the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| word_swap | input | 1 | 0: most-significant half at the lower word; 1: exchanged |
| cnt_inc | input | NUM_REGS-2 | Increment enable per counter register |
| cfg_value | output | 64 | Committed configuration register |
| soft_rst | output | 1 | One-cycle soft reset pulse |

## Verification
The hardest case to reach from the ports is a counter that carries across its 32-bit boundary between the two half reads. That is the only situation in which a torn value could show up. The bench loads a counter just below the carry point while the counter is held. It then raises the increment input in the same cycle as the lower-word read and lets the counter run through the carry before the higher-word read. Snapshot replacement and snapshot flushing on soft reset are driven the same way: the bench places a write or a reset between the two half reads, so that the live and captured values differ.

// File: rtl/s64_pkg.sv
package s64_pkg;

    typedef enum logic {W_EMPTY, W_HELD} wr_state_e;
    typedef enum logic {R_EMPTY, R_HELD} rd_state_e;

    localparam int SRST_BIT = 31;

    // word seen at a given half address for the selected order
    function automatic logic [31:0] word_at(input logic [63:0] v,
                                            input logic hi_addr,
                                            input logic swap);
        return (hi_addr ^ swap) ? v[31:0] : v[63:32];
    endfunction

    // assemble a 64-bit value from the lower-address and higher-address words
    function automatic logic [63:0] join_words(input logic [31:0] w_lo_addr,
                                               input logic [31:0] w_hi_addr,
                                               input logic swap);
        return swap ? {w_hi_addr, w_lo_addr} : {w_lo_addr, w_hi_addr};
    endfunction

endpackage

// File: rtl/s64_write_stager.sv
module s64_write_stager
    import s64_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             half_i,
    input  logic             in_range_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [31:0]      wdata_i,
    input  logic             swap_i,
    output logic             commit_o,
    output logic [IDX_W-1:0] commit_idx_o,
    output logic [63:0]      commit_data_o
);
    wr_state_e   state_q, state_d;
    logic [31:0] stage_q, stage_d;
    logic        wr_ok;

    assign wr_ok = wr_i && in_range_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_EMPTY;
            stage_q <= '0;
        end else begin
            state_q <= state_d;
            stage_q <= stage_d;
        end
    end

    always_comb begin
        state_d = state_q;
        stage_d = stage_q;
        unique case (state_q)
            W_EMPTY: begin
                if (wr_ok && !half_i) begin
                    stage_d = wdata_i;
                    state_d = W_HELD;
                end
            end
            W_HELD: begin
                if (wr_ok && !half_i) begin
                    stage_d = wdata_i;
                end else if (wr_ok && half_i) begin
                    stage_d = '0;
                    state_d = W_EMPTY;
                end
            end
        endcase
    end

    always_comb begin
        commit_o      = wr_ok && half_i;
        commit_idx_o  = idx_i;
        commit_data_o = join_words(stage_q, wdata_i, swap_i);
    end

    // R5: a commit leaves nothing staged for the next one
    a_r5_stage_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (state_q == W_EMPTY && stage_q == 32'd0));

    // R2: a lower-word write always leaves a staged word behind
    a_r2_stage_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !half_i) |=> (state_q == W_HELD && stage_q == $past(wdata_i)));

endmodule

// File: rtl/s64_read_latch.sv
module s64_read_latch
    import s64_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_i,
    input  logic             half_i,
    input  logic             in_range_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [63:0]      live_i,
    input  logic             swap_i,
    input  logic             flush_i,
    output logic [31:0]      rdata_o,
    output logic             rvalid_o
);
    rd_state_e        state_q, state_d;
    logic [IDX_W-1:0] held_idx_q, held_idx_d;
    logic [31:0]      held_word_q, held_word_d;
    logic [31:0]      rdata_q, rdata_d;
    logic             rvalid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= R_EMPTY;
            held_idx_q  <= '0;
            held_word_q <= '0;
            rdata_q     <= '0;
            rvalid_q    <= 1'b0;
        end else begin
            state_q     <= state_d;
            held_idx_q  <= held_idx_d;
            held_word_q <= held_word_d;
            rdata_q     <= rdata_d;
            rvalid_q    <= rd_i;
        end
    end

    always_comb begin
        state_d     = state_q;
        held_idx_d  = held_idx_q;
        held_word_d = held_word_q;
        rdata_d     = rdata_q;
        if (rd_i) begin
            if (!in_range_i) begin
                rdata_d = '0;
            end else if (!half_i) begin
                rdata_d     = word_at(live_i, 1'b0, swap_i);
                held_word_d = word_at(live_i, 1'b1, swap_i);
                held_idx_d  = idx_i;
                state_d     = R_HELD;
            end else begin
                unique case (state_q)
                    R_EMPTY: rdata_d = word_at(live_i, 1'b1, swap_i);
                    R_HELD:  rdata_d = (held_idx_q == idx_i) ? held_word_q
                                                             : word_at(live_i, 1'b1, swap_i);
                endcase
                state_d = R_EMPTY;
            end
        end
        if (flush_i) begin
            state_d = R_EMPTY;
        end
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;

    // R8: a lower-word read always leaves a snapshot held
    a_r8_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && in_range_i && !half_i && !flush_i) |=> (state_q == R_HELD));

    // R7: the held half is the other half of the register at snapshot time
    a_r7_held_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && in_range_i && !half_i) |=> (held_word_q == word_at($past(live_i), 1'b1, $past(swap_i))));

endmodule

// File: rtl/s64_reg_bank.sv
module s64_reg_bank
    import s64_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit_i,
    input  logic [IDX_W-1:0]    commit_idx_i,
    input  logic [63:0]         commit_data_i,
    input  logic [NUM_REGS-3:0] inc_i,
    input  logic [IDX_W-1:0]    rd_idx_i,
    output logic [63:0]         live_o,
    output logic [63:0]         cfg_o,
    output logic                soft_now_o,
    output logic                soft_rst_o
);
    localparam int NUM_CNT = NUM_REGS - 2;
    localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int VIEW_N  = 1 << SEL_W;

    logic [63:0] cfg_q, scratch_q;
    logic [63:0] cnt_q [NUM_CNT];
    logic [63:0] view  [VIEW_N];
    logic        soft_q;
    logic        soft_now;

    assign soft_now = commit_i && (commit_idx_i == '0) && commit_data_i[SRST_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            scratch_q <= '0;
            soft_q    <= 1'b0;
        end else begin
            soft_q <= soft_now;
            if (soft_now) begin
                cfg_q     <= '0;
                scratch_q <= '0;
            end else if (commit_i && commit_idx_i == IDX_W'(0)) begin
                cfg_q <= commit_data_i & ~(64'd1 << SRST_BIT);
            end else if (commit_i && commit_idx_i == IDX_W'(1)) begin
                scratch_q <= commit_data_i;
            end
        end
    end

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        logic load_hit;
        assign load_hit = commit_i && (commit_idx_i == IDX_W'(k + 2));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[k] <= '0;
            end else if (soft_now) begin
                cnt_q[k] <= '0;
            end else if (load_hit) begin
                cnt_q[k] <= commit_data_i;
            end else if (inc_i[k]) begin
                cnt_q[k] <= cnt_q[k] + 64'd1;
            end
        end

        // R9: one step per enabled cycle, carry included
        a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_hit && !soft_now && inc_i[k]) |=> (cnt_q[k] == $past(cnt_q[k]) + 64'd1));
    end

    always_comb begin
        for (int i = 0; i < VIEW_N; i++) begin
            view[i] = '0;
        end
        view[0] = cfg_q;
        view[1] = scratch_q;
        for (int i = 0; i < NUM_CNT; i++) begin
            view[i + 2] = cnt_q[i];
        end
    end

    assign live_o     = (int'(rd_idx_i) < NUM_REGS) ? view[rd_idx_i[SEL_W-1:0]] : '0;
    assign cfg_o      = cfg_q;
    assign soft_now_o = soft_now;
    assign soft_rst_o = soft_q;

    // R6: soft reset pulse comes with a cleared bank
    a_r6_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_now |=> (soft_q && cfg_q == 64'd0 && scratch_q == 64'd0));

    // R2: without a commit the plain register holds
    a_r2_scratch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(scratch_q));

endmodule

// File: rtl/split64_reg_bridge.sv
module split64_reg_bridge
    import s64_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_word_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    input  logic                word_swap,
    input  logic [NUM_REGS-3:0] cnt_inc,
    output logic [63:0]         cfg_value,
    output logic                soft_rst
);
    localparam int IDX_W = ADDR_W - 1;

    logic             half;
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic             commit;
    logic [IDX_W-1:0] commit_idx;
    logic [63:0]      commit_data;
    logic [63:0]      live;
    logic             soft_now;

    assign half     = bus_word_addr[0];
    assign idx      = bus_word_addr[ADDR_W-1:1];
    assign in_range = int'(idx) < NUM_REGS;

    s64_write_stager #(.IDX_W(IDX_W)) stager_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_i          (bus_wr),
        .half_i        (half),
        .in_range_i    (in_range),
        .idx_i         (idx),
        .wdata_i       (bus_wdata),
        .swap_i        (word_swap),
        .commit_o      (commit),
        .commit_idx_o  (commit_idx),
        .commit_data_o (commit_data)
    );

    s64_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) bank_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_i      (commit),
        .commit_idx_i  (commit_idx),
        .commit_data_i (commit_data),
        .inc_i         (cnt_inc),
        .rd_idx_i      (idx),
        .live_o        (live),
        .cfg_o         (cfg_value),
        .soft_now_o    (soft_now),
        .soft_rst_o    (soft_rst)
    );

    s64_read_latch #(.IDX_W(IDX_W)) reader_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (bus_rd),
        .half_i     (half),
        .in_range_i (in_range),
        .idx_i      (idx),
        .live_i     (live),
        .swap_i     (word_swap),
        .flush_i    (soft_now),
        .rdata_o    (bus_rdata),
        .rvalid_o   (bus_rvalid)
    );

    // R10: read data valid exactly one cycle after the strobe
    a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    a_r10_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // R11: an out-of-range read returns zero
    a_r11_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_range) |=> (bus_rdata == 32'd0));

endmodule

// File: tb/split64_reg_bridge_tb.sv
module split64_reg_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 4;
    localparam int AW         = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic            wr = 1'b0;
    logic            rd = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            rvalid;
    logic            swap = 1'b0;
    logic [NREG-3:0] inc = '0;
    logic [63:0]     cfg_value;
    logic            soft_rst;

    int n_chk  = 0;
    int n_fail = 0;
    logic [63:0] model [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    split64_reg_bridge #(.NUM_REGS(NREG), .ADDR_W(AW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_word_addr (addr),
        .bus_wr        (wr),
        .bus_rd        (rd),
        .bus_wdata     (wdata),
        .bus_rdata     (rdata),
        .bus_rvalid    (rvalid),
        .word_swap     (swap),
        .cnt_inc       (inc),
        .cfg_value     (cfg_value),
        .soft_rst      (soft_rst)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] wa(input int r, input int h);
        return AW'(r * 2 + h);
    endfunction

    task automatic wr_word(input logic [AW-1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic rd_word(input logic [AW-1:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        tick();
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic rd64(input int r, output logic [63:0] v);
        logic [31:0] w0, w1;
        rd_word(wa(r, 0), w0);
        rd_word(wa(r, 1), w1);
        v = swap ? {w1, w0} : {w0, w1};
    endtask

    task automatic wr64(input int r, input logic [63:0] v);
        wr_word(wa(r, 0), swap ? v[31:0] : v[63:32]);
        wr_word(wa(r, 1), swap ? v[63:32] : v[31:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic [31:0] w;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 rvalid", 64'(rvalid), 64'd0);
        chk("R1 soft_rst", 64'(soft_rst), 64'd0);
        chk("R1 cfg_value", cfg_value, 64'd0);
        for (int r = 0; r < NREG; r++) begin
            rd64(r, v);
            chk("R1 register", v, 64'd0);
        end
        model[0] = '0;
        model[1] = '0;

        // R10 read valid timing
        rd_word(wa(1, 0), w);
        chk("R10 rvalid after read", 64'(rvalid), 64'd1);
        tick();
        chk("R10 rvalid idle", 64'(rvalid), 64'd0);

        // R2/R3/R4 sweep over order, register and pattern
        for (int sw = 0; sw < 2; sw++) begin
            swap = sw[0];
            for (int r = 0; r < 2; r++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [63:0] val;
                    val = {32'h1000_0000 * 32'(k + 1) + 32'(r * 17) + 32'(sw),
                           32'h0246_8ACE ^ 32'(k << 8) ^ 32'(r << 4)};
                    wr_word(wa(r, 0), swap ? val[31:0] : val[63:32]);
                    rd64(r, v);
                    chk("R2 staged write not visible", v, model[r]);
                    wr_word(wa(r, 1), swap ? val[63:32] : val[31:0]);
                    rd64(r, v);
                    chk("R3 committed value", v, val);
                    rd_word(wa(r, 0), w);
                    chk("R4 lower word order", 64'(w), 64'(swap ? val[31:0] : val[63:32]));
                    rd_word(wa(r, 1), w);
                    if (r == 0) chk("R3 cfg_value", cfg_value, val);
                    model[r] = val;
                end
            end
        end

        // R5 commit without staging
        swap = 1'b0;
        wr_word(wa(1, 1), 32'hCAFE_F00D);
        rd64(1, v);
        chk("R5 zero upper half", v, 64'h0000_0000_CAFE_F00D);
        wr_word(wa(1, 0), 32'h1111_1111);
        wr_word(wa(1, 1), 32'h0000_0002);
        wr_word(wa(1, 1), 32'h0000_0003);
        rd64(1, v);
        chk("R5 stage cleared after commit", v, 64'h0000_0000_0000_0003);
        swap = 1'b1;
        wr_word(wa(1, 1), 32'h0000_5555);
        rd64(1, v);
        chk("R5 zero lower half when swapped", v, 64'h0000_5555_0000_0000);
        swap = 1'b0;

        // R11 out-of-range access
        wr_word(wa(1, 0), 32'hAAAA_0001);
        wr_word(wa(4, 0), 32'hBBBB_0002);
        wr_word(wa(4, 1), 32'h0000_0003);
        wr_word(wa(1, 1), 32'h0000_0004);
        rd64(1, v);
        chk("R11 stage kept over ignored writes", v, 64'hAAAA_0001_0000_0004);
        rd_word(wa(4, 0), w);
        chk("R11 out-of-range read", 64'(w), 64'd0);
        rd_word(wa(31, 1), w);
        chk("R11 top index read", 64'(w), 64'd0);
        rd64(0, v);
        chk("R11 config untouched", v, model[0]);
        model[1] = 64'hAAAA_0001_0000_0004;

        // R9 load wins over increment
        inc = 2'b01;
        wr_word(wa(2, 0), 32'h0);
        wr_word(wa(2, 1), 32'h10);
        inc = 2'b00;
        rd64(2, v);
        chk("R9 load priority", v, 64'h10);
        rd64(3, v);
        chk("R9 idle counter", v, 64'd0);

        // R7/R9 carry between the two half reads
        wr64(2, 64'h0000_0001_FFFF_FFFE);
        inc = 2'b01;
        rd_word(wa(2, 0), w);
        chk("R7 first half at snapshot", 64'(w), 64'h1);
        tick();
        rd_word(wa(2, 1), w);
        inc = 2'b00;
        chk("R7 second half from snapshot", 64'(w), 64'hFFFF_FFFE);
        rd64(2, v);
        chk("R9 carry into upper half", v, 64'h0000_0002_0000_0001);
        inc = 2'b10;
        repeat (5) tick();
        inc = 2'b00;
        rd64(3, v);
        chk("R9 five steps", v, 64'd5);

        // R7/R8 snapshot vs live
        rd_word(wa(1, 0), w);
        wr64(1, 64'h0B0B_0B0B_0C0C_0C0C);
        rd_word(wa(1, 1), w);
        chk("R7 old half after write", 64'(w), 64'h4);
        rd_word(wa(1, 1), w);
        chk("R8 snapshot consumed", 64'(w), 64'h0C0C_0C0C);
        rd_word(wa(1, 0), w);
        wr64(1, 64'h0D0D_0D0D_0E0E_0E0E);
        rd_word(wa(1, 0), w);
        rd_word(wa(1, 1), w);
        chk("R8 newer snapshot wins", 64'(w), 64'h0E0E_0E0E);
        rd_word(wa(1, 0), w);
        rd_word(wa(0, 1), w);
        chk("R8 other register live", 64'(w), 64'(model[0][31:0]));

        // R6 soft reset through a single higher-word write
        rd_word(wa(1, 0), w);
        wr_word(wa(0, 1), 32'h8000_0000);
        chk("R6 pulse high", 64'(soft_rst), 64'd1);
        chk("R6 cfg cleared", cfg_value, 64'd0);
        tick();
        chk("R6 pulse one cycle", 64'(soft_rst), 64'd0);
        rd_word(wa(1, 1), w);
        chk("R6 snapshot flushed", 64'(w), 64'd0);
        rd64(2, v);
        chk("R6 counter cleared", v, 64'd0);
        rd64(0, v);
        chk("R6 config reads zero", v, 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule